// File: doc/BRIEF.md
# Row Gate/Clear Sequencer

This block scans a pixel matrix one row at a time. After a start pulse it walks rows upward from row 0. For each row it raises that row's gate line and holds it through four phases: a setup phase, a first-sample phase, a clear phase and a second-sample phase. During the clear phase it also raises that row's clear line. The column readout takes a sample strobe at the end of each sample phase, and a tag bit tells the first sample from the second. The readout subtracts one sample from the other to remove the pedestal.

The number of rows and the length of each phase are programmable, and they are captured when the start pulse is accepted. When the gate of the last row drops, the block raises a one-cycle frame-done flag. It then idles with every gate off until the next start. Level shifting to high voltage and analog multiplexing are handled outside the block.

Top module: `rowSweeper`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every gate and clear output is low, `sampStrobe`, `sampSecond` and `frameDone` are low, and `rowIndex` is 0.
- R2: At most one gate output is high in any cycle. All gates are low while the block is idle between frames.
- R3: Each row follows the same order. Its gate is high for setupLen cycles, then for samp1Len cycles with `sampStrobe` high and `sampSecond` low in the last of those cycles, then for clearLen cycles with the clear phase active, then for samp2Len cycles with `sampStrobe` and `sampSecond` both high in the last cycle. The gate then falls.
- R4: A clear output is high only during a row's clear phase, only for that row, and only while that row's gate is high.
- R5: Each phase length is a 4-bit value from 1 to 15 clocks, and the value 0 acts as 1. All lengths and the row count are captured at the accepted start, and changing them during a frame has no effect on that frame.
- R6: Rows are scanned from 0 upward to rowCount-1, with `rowIndex` equal to the active row. A rowCount of 0 scans one row, and a rowCount above NUM_ROWS (64) scans NUM_ROWS rows.
- R7: `frameDone` is high for exactly one cycle. That cycle is the one right after the last row's gate falls, and all gates are low in it. The block is idle in the next cycle.
- R8: A start pulse that arrives while a frame is in progress, including the frame-done cycle, is ignored.
- R9: The next row's gate rises in the cycle right after the previous row's gate falls. A row therefore takes exactly the sum of its four phase lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Starts a frame when the block is idle |
| rowCount | input | 7 | Number of rows to scan (clamped to 1..64) |
| setupLen | input | 4 | Setup phase length in clocks (0 acts as 1) |
| samp1Len | input | 4 | First-sample phase length in clocks |
| clearLen | input | 4 | Clear phase length in clocks |
| samp2Len | input | 4 | Second-sample phase length in clocks |
| gateOut | output | 64 | One-hot row gate lines |
| clearOut | output | 64 | One-hot row clear lines |
| sampStrobe | output | 1 | Sample strobe for the column readout |
| sampSecond | output | 1 | High with a strobe that is the second sample |
| rowIndex | output | 6 | Index of the active row |
| frameDone | output | 1 | One-cycle pulse after the last row |

## Verification
The scan is run with several patterns, and each one separates a different class of fault:
- All phase lengths at 1 shows whether phase transitions lose or add a cycle.
- All phase lengths at 15 shows whether a counter is off by one or wraps.
- Unequal lengths show whether the phase lengths have been swapped with one another.
- Zero lengths and out-of-range row counts exercise the clamping rules.
- A full 64-row scan exercises the top row's decoding and the end-of-frame detection.

In directed runs, a start pulse and new settings arrive in the middle of a frame and also during the frame-done cycle. Every cycle is compared against a schedule built from the phase lengths, so a design that restarts the frame or picks up the new values is seen as a change in the gate, clear or strobe pattern.

// File: rtl/rowSweeper_pkg.sv
package rowSweeper_pkg;

  // Sequencer phases; order matches the per-row walk.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_SAMP1 = 3'd2,
    PH_CLEAR = 3'd3,
    PH_SAMP2 = 3'd4,
    PH_DONE  = 3'd5
  } seqPhase_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic      loadCfg;     // capture row count and phase lengths
    logic      rowRestart;  // row counter back to 0
    logic      rowStep;     // advance to next row
    logic      phaseLoad;   // reload phase counter
    seqPhase_e phaseSel;    // which length to reload from
    logic      gateOn;      // drive the current row's gate
    logic      clearOn;     // drive the current row's clear
  } seqCtrl_t;

endpackage

// File: rtl/rowSweeper_ctrl.sv
module rowSweeper_ctrl
  import rowSweeper_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startPulse,
  input  logic     phaseLast,
  input  logic     rowLast,
  output seqCtrl_t ctrl,
  output logic     sampStrobe,
  output logic     sampSecond,
  output logic     frameDone
);

  seqPhase_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext       = state;
    ctrl            = '0;
    ctrl.phaseSel   = PH_IDLE;
    ctrl.gateOn     = (state == PH_SETUP) || (state == PH_SAMP1) ||
                      (state == PH_CLEAR) || (state == PH_SAMP2);
    ctrl.clearOn    = (state == PH_CLEAR);
    unique case (state)
      PH_IDLE: begin
        if (startPulse) begin
          stateNext       = PH_SETUP;
          ctrl.loadCfg    = 1'b1;
          ctrl.rowRestart = 1'b1;
          ctrl.phaseLoad  = 1'b1;
          ctrl.phaseSel   = PH_SETUP;
        end
      end
      PH_SETUP: begin
        if (phaseLast) begin
          stateNext      = PH_SAMP1;
          ctrl.phaseLoad = 1'b1;
          ctrl.phaseSel  = PH_SAMP1;
        end
      end
      PH_SAMP1: begin
        if (phaseLast) begin
          stateNext      = PH_CLEAR;
          ctrl.phaseLoad = 1'b1;
          ctrl.phaseSel  = PH_CLEAR;
        end
      end
      PH_CLEAR: begin
        if (phaseLast) begin
          stateNext      = PH_SAMP2;
          ctrl.phaseLoad = 1'b1;
          ctrl.phaseSel  = PH_SAMP2;
        end
      end
      PH_SAMP2: begin
        if (phaseLast) begin
          if (rowLast) begin
            stateNext = PH_DONE;
          end else begin
            stateNext      = PH_SETUP;
            ctrl.rowStep   = 1'b1;
            ctrl.phaseLoad = 1'b1;
            ctrl.phaseSel  = PH_SETUP;
          end
        end
      end
      PH_DONE: stateNext = PH_IDLE;
      default: stateNext = PH_IDLE;
    endcase
  end

  // Strobe sits in the final cycle of each sampling window.
  assign sampStrobe = phaseLast && ((state == PH_SAMP1) || (state == PH_SAMP2));
  assign sampSecond = phaseLast && (state == PH_SAMP2);
  assign frameDone  = (state == PH_DONE);

endmodule

// File: rtl/rowSweeper_dp.sv
module rowSweeper_dp
  import rowSweeper_pkg::*;
#(
  parameter int NUM_ROWS = 64,
  parameter int PHASE_W  = 4,
  localparam int ROW_W   = $clog2(NUM_ROWS),
  localparam int CNT_W   = ROW_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCtrl_t            ctrl,
  input  logic [CNT_W-1:0]    rowCount,
  input  logic [PHASE_W-1:0]  setupLen,
  input  logic [PHASE_W-1:0]  samp1Len,
  input  logic [PHASE_W-1:0]  clearLen,
  input  logic [PHASE_W-1:0]  samp2Len,
  output logic                phaseLast,
  output logic                rowLast,
  output logic [NUM_ROWS-1:0] gateVec,
  output logic [NUM_ROWS-1:0] clearVec,
  output logic [ROW_W-1:0]    rowIdx
);

  localparam logic [CNT_W-1:0]   ROWS_MAX = CNT_W'(NUM_ROWS);
  localparam logic [PHASE_W-1:0] LEN_ONE  = PHASE_W'(1);

  // Zero length behaves as one clock.
  function automatic logic [PHASE_W-1:0] clampLen(input logic [PHASE_W-1:0] l);
    return (l == '0) ? LEN_ONE : l;
  endfunction

  function automatic logic [ROW_W-1:0] lastRowOf(input logic [CNT_W-1:0] rc);
    logic [CNT_W-1:0] lim;
    lim = (rc == '0) ? CNT_W'(1) : ((rc > ROWS_MAX) ? ROWS_MAX : rc);
    return ROW_W'(lim - CNT_W'(1));
  endfunction

  logic [ROW_W-1:0]   cfgLastRow;
  logic [PHASE_W-1:0] cfgSetup, cfgSamp1, cfgClear, cfgSamp2;
  logic [PHASE_W-1:0] phaseCnt, lenPick;

  // Captured settings, held for the whole frame.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgLastRow <= '0;
      cfgSetup   <= LEN_ONE;
      cfgSamp1   <= LEN_ONE;
      cfgClear   <= LEN_ONE;
      cfgSamp2   <= LEN_ONE;
    end else if (ctrl.loadCfg) begin
      cfgLastRow <= lastRowOf(rowCount);
      cfgSetup   <= clampLen(setupLen);
      cfgSamp1   <= clampLen(samp1Len);
      cfgClear   <= clampLen(clearLen);
      cfgSamp2   <= clampLen(samp2Len);
    end
  end

  // Length for the phase being entered; on the start edge the
  // captured copy is not yet valid, so take the inputs directly.
  always_comb begin
    lenPick = LEN_ONE;
    unique case (ctrl.phaseSel)
      PH_SETUP: lenPick = ctrl.loadCfg ? clampLen(setupLen) : cfgSetup;
      PH_SAMP1: lenPick = cfgSamp1;
      PH_CLEAR: lenPick = cfgClear;
      PH_SAMP2: lenPick = cfgSamp2;
      default:  lenPick = LEN_ONE;
    endcase
  end

  // Down counter; zero marks the final cycle of a phase.
  always_ff @(posedge clk) begin
    if (!rstN)                phaseCnt <= '0;
    else if (ctrl.phaseLoad)  phaseCnt <= lenPick - LEN_ONE;
    else if (phaseCnt != '0)  phaseCnt <= phaseCnt - LEN_ONE;
  end

  assign phaseLast = (phaseCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN)                rowIdx <= '0;
    else if (ctrl.rowRestart) rowIdx <= '0;
    else if (ctrl.rowStep)    rowIdx <= rowIdx + 1'b1;
  end

  assign rowLast = (rowIdx == cfgLastRow);

  // One decoder slice per row channel.
  for (genvar i = 0; i < NUM_ROWS; i++) begin : gRowDec
    logic hit;
    assign hit         = (rowIdx == ROW_W'(i));
    assign gateVec[i]  = ctrl.gateOn  && hit;
    assign clearVec[i] = ctrl.clearOn && hit;
  end

endmodule

// File: rtl/rowSweeper.sv
module rowSweeper
  import rowSweeper_pkg::*;
#(
  parameter int NUM_ROWS = 64,
  parameter int PHASE_W  = 4,
  localparam int ROW_W   = $clog2(NUM_ROWS),
  localparam int CNT_W   = ROW_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic [CNT_W-1:0]    rowCount,
  input  logic [PHASE_W-1:0]  setupLen,
  input  logic [PHASE_W-1:0]  samp1Len,
  input  logic [PHASE_W-1:0]  clearLen,
  input  logic [PHASE_W-1:0]  samp2Len,
  output logic [NUM_ROWS-1:0] gateOut,
  output logic [NUM_ROWS-1:0] clearOut,
  output logic                sampStrobe,
  output logic                sampSecond,
  output logic [ROW_W-1:0]    rowIndex,
  output logic                frameDone
);

  seqCtrl_t ctrl;
  logic     phaseLast, rowLast;

  rowSweeper_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .phaseLast  (phaseLast),
    .rowLast    (rowLast),
    .ctrl       (ctrl),
    .sampStrobe (sampStrobe),
    .sampSecond (sampSecond),
    .frameDone  (frameDone)
  );

  rowSweeper_dp #(
    .NUM_ROWS (NUM_ROWS),
    .PHASE_W  (PHASE_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .rowCount  (rowCount),
    .setupLen  (setupLen),
    .samp1Len  (samp1Len),
    .clearLen  (clearLen),
    .samp2Len  (samp2Len),
    .phaseLast (phaseLast),
    .rowLast   (rowLast),
    .gateVec   (gateOut),
    .clearVec  (clearOut),
    .rowIdx    (rowIndex)
  );

endmodule

// File: rtl/rowSweeper_chk.sv
module rowSweeper_chk #(
  parameter int NUM_ROWS = 64,
  localparam int ROW_W   = $clog2(NUM_ROWS)
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_ROWS-1:0] gateOut,
  input logic [NUM_ROWS-1:0] clearOut,
  input logic                sampStrobe,
  input logic                sampSecond,
  input logic [ROW_W-1:0]    rowIndex,
  input logic                frameDone
);

  AST_GATE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gateOut)); // R2
  AST_CLEAR_UNDER_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (clearOut & ~gateOut) == '0); // R4
  AST_CLEAR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clearOut)); // R4
  AST_STROBE_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rstN)
    sampStrobe |-> (gateOut != '0 && clearOut == '0)); // R3
  AST_TAG_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    sampSecond |-> sampStrobe); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone); // R7
  AST_DONE_GATES_OFF: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> gateOut == '0); // R7
  AST_ROW_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (gateOut != '0) |-> gateOut[rowIndex]); // R6

endmodule

bind rowSweeper rowSweeper_chk #(.NUM_ROWS(NUM_ROWS)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .gateOut    (gateOut),
  .clearOut   (clearOut),
  .sampStrobe (sampStrobe),
  .sampSecond (sampSecond),
  .rowIndex   (rowIndex),
  .frameDone  (frameDone)
);

// File: tb/rowSweeper_test.sv
module rowSweeper_test;
  localparam int NR = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic [6:0]    rowCount = '0;
  logic [3:0]    setupLen = '0, samp1Len = '0, clearLen = '0, samp2Len = '0;
  logic [NR-1:0] gateOut, clearOut;
  logic          sampStrobe, sampSecond, frameDone;
  logic [5:0]    rowIndex;

  int totalCnt = 0;
  int passCnt  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rowSweeper #(.NUM_ROWS(NR), .PHASE_W(4)) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .rowCount(rowCount),
    .setupLen(setupLen), .samp1Len(samp1Len), .clearLen(clearLen),
    .samp2Len(samp2Len), .gateOut(gateOut), .clearOut(clearOut),
    .sampStrobe(sampStrobe), .sampSecond(sampSecond), .rowIndex(rowIndex),
    .frameDone(frameDone)
  );

  // {rowCount, setup, samp1, clear, samp2}
  localparam logic [22:0] VEC [8] = '{
    {7'd3,   4'd1,  4'd1,  4'd1,  4'd1 },
    {7'd2,   4'd15, 4'd15, 4'd15, 4'd15},
    {7'd4,   4'd2,  4'd3,  4'd1,  4'd4 },
    {7'd0,   4'd3,  4'd1,  4'd2,  4'd1 },
    {7'd1,   4'd1,  4'd2,  4'd3,  4'd4 },
    {7'd2,   4'd0,  4'd0,  4'd0,  4'd0 },
    {7'd64,  4'd1,  4'd1,  4'd1,  4'd1 },
    {7'd100, 4'd1,  4'd2,  4'd1,  4'd1 }
  };

  task automatic report();
    $display("%0d/%0d checks passed", passCnt, totalCnt);
  endtask

  task automatic checkCycle(input string req, input logic [NR-1:0] gExp,
                            input logic [NR-1:0] cExp, input logic sExp,
                            input logic tExp, input logic dExp,
                            input logic [5:0] rExp, input bit rowChk);
    bit bad;
    bad = (gateOut !== gExp) || (clearOut !== cExp) || (sampStrobe !== sExp) ||
          (sampSecond !== tExp) || (frameDone !== dExp) ||
          (rowChk && rowIndex !== rExp);
    totalCnt++;
    if (bad)
      $display("FAIL %s: got gate=%h clear=%h strb=%b tag=%b done=%b row=%0d exp gate=%h clear=%h strb=%b tag=%b done=%b row=%0d",
               req, gateOut, clearOut, sampStrobe, sampSecond, frameDone, rowIndex,
               gExp, cExp, sExp, tExp, dExp, rExp);
    else passCnt++;
  endtask

  // Runs one frame from the idle state; at cycle index disturbAt a start
  // pulse plus new settings are applied (negative: never).
  task automatic runFrame(input int rc, input int s, input int a, input int c,
                          input int b, input int disturbAt, input string tag);
    int effRows, cyc;
    int len [4];
    effRows = (rc == 0) ? 1 : ((rc > NR) ? NR : rc);
    len[0] = (s == 0) ? 1 : s;
    len[1] = (a == 0) ? 1 : a;
    len[2] = (c == 0) ? 1 : c;
    len[3] = (b == 0) ? 1 : b;
    rowCount = 7'(rc); setupLen = 4'(s); samp1Len = 4'(a);
    clearLen = 4'(c);  samp2Len = 4'(b);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    cyc = 0;
    for (int r = 0; r < effRows; r++) begin
      for (int ph = 0; ph < 4; ph++) begin
        for (int k = 0; k < len[ph]; k++) begin
          logic [NR-1:0] g;
          logic strb, sec;
          string lab;
          g = '0; g[r] = 1'b1;
          strb = (ph == 1 || ph == 3) && (k == len[ph] - 1);
          sec  = (ph == 3) && strb;
          if (ph == 2)                         lab = "R4 clear phase";
          else if (strb)                       lab = "R3 sample strobe";
          else if (ph == 0 && k == 0 && r > 0) lab = "R9 next row";
          else                                 lab = "R6 row walk";
          checkCycle({tag, " ", lab}, g, (ph == 2) ? g : '0, strb, sec, 1'b0,
                     6'(r), 1'b1);
          if (cyc == disturbAt) begin
            startPulse = 1'b1;
            rowCount = 7'd64; setupLen = 4'd7; samp1Len = 4'd7;
            clearLen = 4'd7; samp2Len = 4'd7;
          end else startPulse = 1'b0;
          @(negedge clk);
          cyc++;
        end
      end
    end
    checkCycle({tag, " R7 done pulse"}, '0, '0, 1'b0, 1'b0, 1'b1, 6'd0, 1'b0);
    if (cyc == disturbAt) startPulse = 1'b1;
    else startPulse = 1'b0;
    @(negedge clk);
    checkCycle({tag, " R7 idle after done"}, '0, '0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0);
    startPulse = 1'b0;
    @(negedge clk);
    checkCycle({tag, " R2 idle gates off"}, '0, '0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      totalCnt++;
      $display("FAIL watchdog: got timeout exp finish");
      report();
      $finish;
    end
  end

  initial begin
    // R1: reset state, start held high during reset has no effect
    startPulse = 1'b1;
    repeat (3) @(negedge clk);
    checkCycle("R1 in reset", '0, '0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b1);
    startPulse = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    checkCycle("R1 after reset", '0, '0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b1);
    @(negedge clk);
    checkCycle("R2 idle no start", '0, '0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0);

    // Table walk
    for (int i = 0; i < 8; i++)
      runFrame(int'(VEC[i][22:16]), int'(VEC[i][15:12]), int'(VEC[i][11:8]),
               int'(VEC[i][7:4]), int'(VEC[i][3:0]), -1,
               (i == 5) ? "R5 zero len" : "R6 table");

    // R8/R5: start plus new settings in mid-frame
    runFrame(3, 2, 2, 3, 2, 5, "R8 R5 mid-frame start");
    // R8: start during the frame-done cycle (3 rows x 4 cycles = 12)
    runFrame(3, 1, 1, 1, 1, 12, "R8 start at done");
    // Frame right after an ignored start still behaves normally
    runFrame(2, 1, 3, 1, 2, -1, "R9 follow-up");

    finished = 1;
    report();
    $finish;
  end

endmodule